// File: doc/BRIEF.md
# RS485 Framed Message Transmitter

This block sends one fixed-length message over a half-duplex RS485 link. A single-cycle start pulse latches ten payload bytes: two address bytes, a type byte, two code bytes, a sign byte and four data bytes. The block then switches the line transceiver into drive mode and waits a programmable number of clock cycles so the bus can settle. After that it passes fifteen bytes, one at a time, to a byte-wide UART transmitter over a valid/ready handshake.

The fifteen bytes are the payload, three constant marker bytes and a 16-bit additive checksum. The block does not release the bus when the UART accepts the last byte. It releases the bus only after the UART reports that its shift register has emptied, so the final stop bit is never cut off.

The UART's sticky transmit-complete flag is cleared when the frame starts and again on every accepted byte. Because of this, a completion left over from an earlier frame cannot end the frame early, and neither can a gap between two bytes.

Top module: `rs485_msg_tx`

## Requirements
- R1: A frame carries exactly 15 bytes, in this transfer order: 0x00, addrA, addrB, 0x05, dataType, codeA, codeB, signByte, dataB0, dataB1, dataB2, dataB3, 0x03, sum high byte, sum low byte.
- R2: The checksum is the 16-bit unsigned sum of the ten payload bytes plus the constants 5 and 3, taken modulo 65536.
- R3: The checksum high byte (bits 15:8) is transferred before the low byte (bits 7:0), as positions 13 and 14 of the frame.
- R4: Driver enable `de` rises on the clock edge that samples `start`. `txValid` first goes high exactly PRE_CYCLES cycles after that edge.
- R5: `de` stays high after the last byte is accepted. It falls on the edge after `txComplete` is first seen high in the draining phase, so the UART holding and shift stages are both empty when it drops.
- R6: `txClear` pulses in the first cycle that `de` is high and in every cycle in which a byte is accepted, which is 16 pulses per frame. A transmit-complete flag that is already set before the frame starts does not shorten the frame.
- R7: `busy` is high from the edge that samples `start` until `de` falls, and is equal to `de`. A `start` pulse that arrives while `busy` is high is ignored and does not add bytes to the frame.
- R8: Payload inputs are captured on the `start` edge. Changing them while a frame is in progress has no effect on the bytes sent.
- R9: While `txValid` is high and `txReady` is low, `txValid` stays high and `txData` stays unchanged on the next cycle. A byte is transferred in each cycle where both are high.
- R10: While reset is asserted, `de`, `busy`, `txValid` and `txClear` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request to send a frame |
| addrA | input | 8 | First address byte |
| addrB | input | 8 | Second address byte |
| dataType | input | 8 | Message type byte |
| codeA | input | 8 | First code byte |
| codeB | input | 8 | Second code byte |
| signByte | input | 8 | Sign byte |
| dataB0 | input | 8 | Data byte 0 |
| dataB1 | input | 8 | Data byte 1 |
| dataB2 | input | 8 | Data byte 2 |
| dataB3 | input | 8 | Data byte 3 |
| txData | output | 8 | Byte offered to the UART |
| txValid | output | 1 | `txData` is valid |
| txReady | input | 1 | UART accepts the byte this cycle |
| txComplete | input | 1 | UART sticky flag: shift register empty and nothing pending |
| txClear | output | 1 | Clears the UART transmit-complete flag |
| de | output | 1 | RS485 driver enable |
| busy | output | 1 | Frame in progress |

## Verification
The bench sends several frame patterns and checks each one against a byte list computed in the bench:
- An all-zero payload shows whether the marker bytes sit in the right positions, because the checksum is just 8.
- An all-0xFF payload exercises the carries into the checksum high byte, which separates a byte-swapped checksum from a correct one.
- Random payloads from a fixed seed catch field-ordering mistakes.
- A UART model with random stalls and a slow shifter checks handshake holding and bus release timing.
- The transmit-complete flag is set before every frame, and some frames get a second start pulse and payload changes while they are being sent, to show that stale status, repeated starts and late data are all ignored.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

  localparam int FRAME_LEN  = 15;
  localparam int NUM_FIELDS = 10;
  localparam int BYTE_W     = 8;
  localparam int SUM_W      = 16;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  localparam logic [BYTE_W-1:0] MARK_HEAD = 8'h00;
  localparam logic [BYTE_W-1:0] MARK_MID  = 8'h05;
  localparam logic [BYTE_W-1:0] MARK_TAIL = 8'h03;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEND,
    ST_DRAIN
  } txState_e;

  typedef struct packed {
    logic capture;
    logic idxClr;
    logic idxInc;
  } dpCtl_t;

endpackage

// File: rtl/rs485_tx_datapath.sv
module rs485_tx_datapath
  import rs485_tx_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  dpCtl_t                              ctl,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0]   fieldsIn,
  output logic [BYTE_W-1:0]                   byteOut,
  output logic                                lastByte
);

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fieldQ;
  logic [SUM_W-1:0]                  sumD;
  logic [SUM_W-1:0]                  sumQ;
  logic [IDX_W-1:0]                  idxQ;

  // Checksum over the live inputs; registered together with the capture.
  always_comb begin
    sumD = SUM_W'(MARK_MID) + SUM_W'(MARK_TAIL);
    for (int i = 0; i < NUM_FIELDS; i++) begin
      sumD = sumD + SUM_W'(fieldsIn[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldQ <= '0;
      sumQ   <= '0;
    end else if (ctl.capture) begin
      fieldQ <= fieldsIn;
      sumQ   <= sumD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (ctl.idxClr) begin
      idxQ <= '0;
    end else if (ctl.idxInc && idxQ != IDX_W'(FRAME_LEN - 1)) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  // Frame layout: head marker, two fields, mid marker, eight fields,
  // tail marker, checksum high, checksum low.
  always_comb begin
    byteOut = '0;
    if (idxQ == IDX_W'(0)) begin
      byteOut = MARK_HEAD;
    end else if (idxQ <= IDX_W'(2)) begin
      byteOut = fieldQ[idxQ - IDX_W'(1)];
    end else if (idxQ == IDX_W'(3)) begin
      byteOut = MARK_MID;
    end else if (idxQ <= IDX_W'(11)) begin
      byteOut = fieldQ[idxQ - IDX_W'(2)];
    end else if (idxQ == IDX_W'(12)) begin
      byteOut = MARK_TAIL;
    end else if (idxQ == IDX_W'(13)) begin
      byteOut = sumQ[SUM_W-1:BYTE_W];
    end else if (idxQ == IDX_W'(14)) begin
      byteOut = sumQ[BYTE_W-1:0];
    end
  end

  assign lastByte = (idxQ == IDX_W'(FRAME_LEN - 1));

  // R1: the index never steps past the last frame position
  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= IDX_W'(FRAME_LEN - 1));

  // R8: captured payload only changes on a capture strobe
  a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(fieldQ));

endmodule

// File: rtl/rs485_tx_ctrl.sv
module rs485_tx_ctrl
  import rs485_tx_pkg::*;
#(
  parameter int PRE_CYCLES = 50000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   txReady,
  input  logic   txComplete,
  input  logic   lastByte,
  output dpCtl_t ctl,
  output logic   txValid,
  output logic   txClear,
  output logic   de,
  output logic   busy
);

  localparam int CNT_W = $clog2(PRE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYCLES - 1);

  txState_e       stateQ, stateD;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (start) stateD = ST_PRE;
      ST_PRE:   if (cntQ == PRE_LAST) stateD = ST_SEND;
      ST_SEND:  if (txReady && lastByte) stateD = ST_DRAIN;
      ST_DRAIN: if (txComplete) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (stateQ != ST_PRE) begin
      cntQ <= '0;
    end else if (cntQ != PRE_LAST) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign ctl.capture = (stateQ == ST_IDLE) && start;
  assign ctl.idxClr  = (stateQ == ST_IDLE) && start;
  assign ctl.idxInc  = (stateQ == ST_SEND) && txReady;

  assign txValid = (stateQ == ST_SEND);
  assign txClear = ((stateQ == ST_PRE) && (cntQ == '0)) ||
                   ((stateQ == ST_SEND) && txReady);
  assign de      = (stateQ != ST_IDLE);
  assign busy    = de;

  // R4: no byte is offered unless the driver is on
  a_r4_valid_needs_de: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> de);

  // R5: the driver drops only after completion was reported
  a_r5_release_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(de) |-> $past(txComplete) && !$past(txValid));

  // R6: a fresh frame clears the completion flag first
  a_r6_clear_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(de) |-> txClear);

  // R7: a start while busy in the middle of a frame keeps the frame going
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !txComplete |=> busy);

  // R9: an offered byte stays offered until taken
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);

  // R10: quiet outputs while in reset
  always_comb begin
    if (!rstN) begin
      a_r10_reset_quiet: assert (!de && !busy && !txValid && !txClear);
    end
  end

endmodule

// File: rtl/rs485_msg_tx.sv
module rs485_msg_tx
  import rs485_tx_pkg::*;
#(
  parameter int PRE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] addrA,
  input  logic [7:0] addrB,
  input  logic [7:0] dataType,
  input  logic [7:0] codeA,
  input  logic [7:0] codeB,
  input  logic [7:0] signByte,
  input  logic [7:0] dataB0,
  input  logic [7:0] dataB1,
  input  logic [7:0] dataB2,
  input  logic [7:0] dataB3,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       txReady,
  input  logic       txComplete,
  output logic       txClear,
  output logic       de,
  output logic       busy
);

  dpCtl_t                            ctl;
  logic                              lastByte;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fields;

  assign fields = {dataB3, dataB2, dataB1, dataB0, signByte,
                   codeB, codeA, dataType, addrB, addrA};

  rs485_tx_ctrl #(
    .PRE_CYCLES(PRE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .txReady   (txReady),
    .txComplete(txComplete),
    .lastByte  (lastByte),
    .ctl       (ctl),
    .txValid   (txValid),
    .txClear   (txClear),
    .de        (de),
    .busy      (busy)
  );

  rs485_tx_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .fieldsIn(fields),
    .byteOut (txData),
    .lastByte(lastByte)
  );

  // R9: offered data is stable while the UART stalls
  a_r9_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> $stable(txData));

endmodule

// File: tb/sim_rs485_msg_tx.sv
module sim_rs485_msg_tx;

  localparam int PRE   = 20;
  localparam int SHIFT = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [9:0][7:0] fld = '0;
  logic [7:0] txData;
  logic txValid, txReady, txComplete, txClear, de, busy;

  always #2 clk = ~clk;

  rs485_msg_tx #(.PRE_CYCLES(PRE)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .addrA(fld[0]), .addrB(fld[1]), .dataType(fld[2]), .codeA(fld[3]),
    .codeB(fld[4]), .signByte(fld[5]), .dataB0(fld[6]), .dataB1(fld[7]),
    .dataB2(fld[8]), .dataB3(fld[9]),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .txComplete(txComplete), .txClear(txClear), .de(de), .busy(busy)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // UART model: one holding byte, slow shifter, sticky completion flag
  logic holdFull;
  int   shiftCnt;
  logic doneFlag;
  logic stallOk = 1'b1;
  logic [7:0] rxBuf [0:511];
  int   rxN = 0;
  int   clrN = 0;
  int   monErr = 0;
  logic prevPend = 1'b0;
  logic [7:0] prevData = '0;

  assign txReady    = !holdFull && stallOk;
  assign txComplete = doneFlag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      shiftCnt <= 0;
      doneFlag <= 1'b1;
    end else begin
      if (txValid && txReady) begin
        rxBuf[rxN] <= txData;
        rxN        <= rxN + 1;
        holdFull   <= 1'b1;
      end else if (holdFull && shiftCnt <= 1) begin
        holdFull <= 1'b0;
      end
      if (holdFull && shiftCnt <= 1) shiftCnt <= SHIFT;
      else if (shiftCnt > 0)         shiftCnt <= shiftCnt - 1;
      if (txClear)                          doneFlag <= 1'b0;
      else if (shiftCnt == 1 && !holdFull)  doneFlag <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (txClear) clrN <= clrN + 1;
      if (prevPend && (!txValid || txData != prevData)) monErr <= monErr + 1;
      if (busy != de) monErr <= monErr + 1;
      prevPend <= txValid && !txReady;
      prevData <= txData;
    end
  end

  always @(negedge clk) stallOk <= (($urandom % 4) != 0);

  function automatic logic [7:0] expByte(input logic [9:0][7:0] f, input int k);
    logic [15:0] s;
    s = 16'd8;
    for (int i = 0; i < 10; i++) s = s + 16'(f[i]);
    case (k)
      0:  return 8'h00;
      1:  return f[0];
      2:  return f[1];
      3:  return 8'h05;
      12: return 8'h03;
      13: return s[15:8];
      14: return s[7:0];
      default: return f[k-2];
    endcase
  endfunction

  task automatic runFrame(input logic [9:0][7:0] f, input bit poke);
    int base, clrBase, n, t;
    base = rxN;
    clrBase = clrN;
    @(negedge clk);
    fld = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(de && busy, "R4", "de/busy after start", {de, busy}, 3);
    for (int i = 0; i < 10; i++) fld[i] = 8'($urandom);  // R8 late changes
    n = 0;
    while (!txValid && n < 5000) begin
      n++;
      if (poke && n == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check(n == PRE, "R4", "cycles de before first valid", n, PRE);
    t = 0;
    while (de && t < 20000) begin
      t++;
      if (poke && t == 40) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check(!de && !busy, "R7", "busy/de released", {de, busy}, 0);
    check(!holdFull && shiftCnt == 0, "R5", "UART idle at release",
          {holdFull, 8'(shiftCnt)}, 0);
    check(rxN - base == 15, "R1", "byte count", rxN - base, 15);
    for (int k = 0; k < 15; k++) begin
      logic [7:0] e;
      e = expByte(f, k);
      check(rxBuf[base + k] == e, k >= 13 ? "R3" : "R1", $sformatf("byte %0d", k),
            rxBuf[base + k], e);
    end
    check({rxBuf[base + 13], rxBuf[base + 14]} == expByte(f, 13) * 256 + expByte(f, 14),
          "R2", "checksum", {rxBuf[base + 13], rxBuf[base + 14]},
          expByte(f, 13) * 256 + expByte(f, 14));
    check(clrN - clrBase == 16, "R6", "clear pulses", clrN - clrBase, 16);
    repeat (3) @(negedge clk);
    check(!de && !busy, "R7", "stays idle after ignored start", {de, busy}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "timeout", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [9:0][7:0] f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!de && !busy && !txValid && !txClear, "R10", "reset outputs",
          {de, busy, txValid, txClear}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!de && !busy && !txValid, "R10", "idle after reset", {de, busy, txValid}, 0);
    check(txComplete, "R6", "stale completion flag set before frame", txComplete, 1);
    runFrame('0, 1'b0);
    for (int i = 0; i < 10; i++) f[i] = 8'hFF;
    runFrame(f, 1'b1);
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 10; i++) f[i] = 8'($urandom);
      runFrame(f, r[0]);
    end
    check(monErr == 0, "R9", "handshake hold / busy==de monitor", monErr, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule